// File: doc/BRIEF.md
# Software Write-Protect Sequence Guard

This block sits beside the write path of a paged nonvolatile byte array. It sees every byte write that the bus side accepts, with a 15-bit address and an 8-bit data value, and decides for each one whether the byte goes into the array (commit) or is dropped (discard). It also holds a write-protect flag that software turns on and off with fixed keyed command sequences. The sequences are made of writes that are consumed and never stored. Outside a sequence, the addresses they use remain ordinary locations.

Writes arrive in load phases. Every write reopens a byte-load window. When the window runs out with no new write, a program period of fixed length follows, and writes during that period are ignored. A completed lock or unlock sequence only records a pending change. The protect flag takes the new value when the program period of that phase ends, even if no data bytes followed the sequence. While protection is on, a phase that does not begin with the lock sequence still runs the program period, but every byte in it is discarded. A phase that does begin with the lock sequence stores the bytes that follow the sequence.

Top module: `wp_seq_guard`

## Requirements
- R1: After a synchronous active-low reset, `prot_on` is 0, `prog_busy` is 0 and `dec_valid` is 0.
- R2: Each accepted write restarts the byte-load window. Once `LOAD_WIN` clock edges pass with no write, `prog_busy` goes high for exactly `PROG_CYCLES` cycles. A write arriving `LOAD_WIN` edges after the previous one still belongs to the same phase.
- R3: A write presented while `prog_busy` is high is ignored. It produces no decision and it does not advance any sequence.
- R4: With protection off, an ordinary write has `dec_commit` = 1.
- R5: The lock sequence is data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. It is matched only when it starts with the first write of a load phase. Its three bytes are discarded. `prot_on` becomes 1 when that phase's program period ends, even if no data bytes followed.
- R6: Bytes that follow a completed lock or unlock sequence in the same phase are committed, whatever the protect state.
- R7: With protection on, a phase without the lock sequence discards all of its bytes and still runs the program period.
- R8: The unlock sequence is six writes: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. Its bytes are discarded. `prot_on` becomes 0 when that phase's program period ends.
- R9: If a write does not match the next expected sequence step, matching stops for the rest of the phase. That write, and every later write in the phase, is treated as ordinary under the current protect state.
- R10: `dec_valid` pulses for one cycle, on the cycle after each accepted write. `dec_commit` is only ever 1 together with `dec_valid`.
- R11: `prot_on` changes only on the clock edge where a program period ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | A byte write is presented this cycle |
| wr_addr | input | 15 | Byte address of the write |
| wr_data | input | 8 | Byte value of the write |
| dec_valid | output | 1 | A decision for the previous cycle's write is present |
| dec_commit | output | 1 | 1: store the byte; 0: discard it |
| prot_on | output | 1 | Write protection currently active |
| prog_busy | output | 1 | Program period running; writes are ignored |

## Verification
The assertions assume that `wr_valid`, `wr_addr` and `wr_data` hold one value per cycle, and that the array timer does not end a program period in the same cycle that a write is accepted. The block keeps that second condition itself, because it refuses writes while busy. The stimulus changes inputs only on the falling clock edge and holds each write for exactly one cycle. Its sequences use inter-write gaps up to the window limit and one gap past it, so that a sequence broken by the timer is also covered. Every write made during a program period is deliberate and tests that busy writes are ignored.

// File: rtl/wp_seq_pkg.sv
// Shared constants, types and the keyed-step matcher for the write-protect guard.
// Assumes the low 15 address bits identify the command locations.
package wp_seq_pkg;

    localparam int ADDR_W = 15;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [ADDR_W-1:0] KEY_ADDR_B = 15'h2AAA;
    localparam logic [DATA_W-1:0] KEY_D_FIRST  = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_D_SECOND = 8'h55;
    localparam logic [DATA_W-1:0] KEY_D_LOCK   = 8'hA0;
    localparam logic [DATA_W-1:0] KEY_D_EXTEND = 8'h80;
    localparam logic [DATA_W-1:0] KEY_D_UNLOCK = 8'h20;

    // Tracker position inside a load phase.
    typedef enum logic [2:0] {
        TS_START, TS_S1, TS_S2, TS_S3, TS_S4, TS_S5, TS_ORD, TS_UNLK
    } trk_state_t;

    // Protect change waiting for the end of the program period.
    typedef enum logic [1:0] {
        PD_NONE, PD_SET, PD_CLR
    } pend_t;

    // True when the write matches the shared step that the state expects next.
    function automatic logic step_match(trk_state_t st,
                                        logic [ADDR_W-1:0] a,
                                        logic [DATA_W-1:0] d);
        case (st)
            TS_START, TS_S3: return (a == KEY_ADDR_A) && (d == KEY_D_FIRST);
            TS_S1,    TS_S4: return (a == KEY_ADDR_B) && (d == KEY_D_SECOND);
            default:         return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/wp_phase_timer.sv
// Load-window and program-period timer.
// Each write reopens a window of LOAD_WIN edges. When the window expires, a
// busy period of PROG_CYCLES cycles follows, during which writes are refused.
// Assumes LOAD_WIN >= 1 and PROG_CYCLES >= 1.
module wp_phase_timer #(
    parameter int LOAD_WIN    = 15000,
    parameter int PROG_CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_valid,
    output logic accept,
    output logic busy,
    output logic prog_end
);
    localparam int WIN_W = $clog2(LOAD_WIN + 1);
    localparam int PRG_W = $clog2(PROG_CYCLES + 1);

    logic             phase_open;
    logic [WIN_W-1:0] win_cnt;
    logic [PRG_W-1:0] prg_cnt;

    // Writes are taken only outside the program period.
    assign accept   = wr_valid & ~busy;
    // Last busy cycle: the array finishes programming on this edge.
    assign prog_end = busy && (prg_cnt == PRG_W'(PROG_CYCLES - 1));

    // Advance the window and program counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_open <= 1'b0;
            win_cnt    <= '0;
            prg_cnt    <= '0;
            busy       <= 1'b0;
        end else if (busy) begin
            if (prog_end) begin
                busy    <= 1'b0;
                prg_cnt <= '0;
            end else begin
                prg_cnt <= prg_cnt + PRG_W'(1);
            end
        end else if (wr_valid) begin
            phase_open <= 1'b1;
            win_cnt    <= '0;
        end else if (phase_open) begin
            if (win_cnt == WIN_W'(LOAD_WIN - 1)) begin
                phase_open <= 1'b0;
                busy       <= 1'b1;
                prg_cnt    <= '0;
            end else begin
                win_cnt <= win_cnt + WIN_W'(1);
            end
        end
    end

    AST_BUSY_FOLLOWS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(phase_open)); // R2

endmodule

// File: rtl/wp_cmd_tracker.sv
// Keyed command tracker. It walks the lock and unlock sequences from the first
// write of each load phase and gives a commit/discard decision for each
// accepted write. Assumes prog_end and accept never coincide.
module wp_cmd_tracker
    import wp_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              prog_end,
    input  logic              prot_on,
    output logic              dec_valid,
    output logic              dec_commit,
    output logic              req_set,
    output logic              req_clr
);
    trk_state_t state, nxt;
    logic       commit;

    // Next position and decision for the presented write.
    always_comb begin
        nxt     = state;
        commit  = 1'b0;
        req_set = 1'b0;
        req_clr = 1'b0;
        case (state)
            TS_UNLK: commit = 1'b1;
            TS_S2: begin
                if (addr == KEY_ADDR_A && data == KEY_D_LOCK) begin
                    nxt     = TS_UNLK;
                    req_set = accept;
                end else if (addr == KEY_ADDR_A && data == KEY_D_EXTEND) begin
                    nxt = TS_S3;
                end else begin
                    nxt    = TS_ORD;
                    commit = ~prot_on;
                end
            end
            TS_S5: begin
                if (addr == KEY_ADDR_A && data == KEY_D_UNLOCK) begin
                    nxt     = TS_UNLK;
                    req_clr = accept;
                end else begin
                    nxt    = TS_ORD;
                    commit = ~prot_on;
                end
            end
            TS_ORD: commit = ~prot_on;
            default: begin
                if (step_match(state, addr, data)) begin
                    nxt = trk_state_t'(state + 3'd1);
                end else begin
                    nxt    = TS_ORD;
                    commit = ~prot_on;
                end
            end
        endcase
    end

    // Register the decision and the tracker position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= TS_START;
            dec_valid  <= 1'b0;
            dec_commit <= 1'b0;
        end else begin
            dec_valid  <= accept;
            dec_commit <= accept & commit;
            if (prog_end)    state <= TS_START;
            else if (accept) state <= nxt;
        end
    end

    AST_COMMIT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        dec_commit |-> dec_valid); // R10
    AST_UNLOCKED_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && state == TS_UNLK) |=> (dec_valid && dec_commit)); // R6

endmodule

// File: rtl/wp_prot_reg.sv
// Protect flag and pending change. A request from the tracker is held until the
// program period ends, and then applied. Assumes the requests and prog_end are
// never active together.
module wp_prot_reg
    import wp_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_set,
    input  logic req_clr,
    input  logic prog_end,
    output logic prot_on
);
    pend_t pend;

    // Hold the request and apply it at the end of the program period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_on <= 1'b0;
            pend    <= PD_NONE;
        end else if (prog_end) begin
            if (pend == PD_SET)      prot_on <= 1'b1;
            else if (pend == PD_CLR) prot_on <= 1'b0;
            pend <= PD_NONE;
        end else if (req_set) begin
            pend <= PD_SET;
        end else if (req_clr) begin
            pend <= PD_CLR;
        end
    end

    AST_PROT_AT_PERIOD_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prot_on) |-> $past(prog_end)); // R11
    AST_RISE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_on) |-> $past(pend == PD_SET)); // R5
    AST_FALL_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_on) |-> $past(pend == PD_CLR)); // R8

endmodule

// File: rtl/wp_seq_guard.sv
// Top of the software write-protect guard: timer, tracker and protect flag.
// Assumes wr_* hold a single byte write for one cycle when wr_valid is high.
module wp_seq_guard #(
    parameter int LOAD_WIN    = 15000,
    parameter int PROG_CYCLES = 1000000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_valid,
    input  logic [14:0] wr_addr,
    input  logic [7:0]  wr_data,
    output logic        dec_valid,
    output logic        dec_commit,
    output logic        prot_on,
    output logic        prog_busy
);
    logic accept, prog_end, req_set, req_clr;

    wp_phase_timer #(.LOAD_WIN(LOAD_WIN), .PROG_CYCLES(PROG_CYCLES)) timer_i (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid),
        .accept(accept), .busy(prog_busy), .prog_end(prog_end)
    );

    wp_cmd_tracker tracker_i (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .addr(wr_addr), .data(wr_data), .prog_end(prog_end), .prot_on(prot_on),
        .dec_valid(dec_valid), .dec_commit(dec_commit),
        .req_set(req_set), .req_clr(req_clr)
    );

    wp_prot_reg prot_i (
        .clk(clk), .rst_n(rst_n), .req_set(req_set), .req_clr(req_clr),
        .prog_end(prog_end), .prot_on(prot_on)
    );

    AST_BUSY_NO_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |=> !dec_valid); // R3

endmodule

// File: tb/wp_seq_guard_tb_top.sv
module wp_seq_guard_tb_top;
    localparam int LW = 4;
    localparam int PC = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        dec_valid, dec_commit, prot_on, prog_busy;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit cmp_on = 1'b0;

    always #5 clk = ~clk;

    wp_seq_guard #(.LOAD_WIN(LW), .PROG_CYCLES(PC)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .dec_valid(dec_valid), .dec_commit(dec_commit),
        .prot_on(prot_on), .prog_busy(prog_busy)
    );

    // Behavioural reference model, updated from the inputs seen at each edge.
    int m_busy, m_open, m_win, m_prog, m_prot, m_pend, m_step, m_dv, m_dc;
    int seq_a[6] = '{32'h5555, 32'h2AAA, 32'h5555, 32'h5555, 32'h2AAA, 32'h5555};
    int seq_d[6] = '{32'hAA, 32'h55, 32'h80, 32'hAA, 32'h55, 32'h20};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_open = 0; m_win = 0; m_prog = 0;
            m_prot = 0; m_pend = 0; m_step = 0; m_dv = 0; m_dc = 0;
        end else begin
            m_dv = 0; m_dc = 0;
            if (m_busy != 0) begin
                m_prog++;
                if (m_prog == PC) begin
                    m_busy = 0;
                    if (m_pend == 1) m_prot = 1;
                    if (m_pend == 2) m_prot = 0;
                    m_pend = 0; m_step = 0;
                end
            end else if (wr_valid) begin
                m_open = 1; m_win = 0; m_dv = 1;
                if (m_step == 7) m_dc = 1;
                else if (m_step <= 5 && int'(wr_addr) == seq_a[m_step]
                         && int'(wr_data) == seq_d[m_step]) begin
                    if (m_step == 5) begin m_step = 7; m_pend = 2; end
                    else m_step++;
                end else if (m_step == 2 && wr_addr == 15'h5555 && wr_data == 8'hA0) begin
                    m_step = 7; m_pend = 1;
                end else begin
                    m_dc = (m_prot == 0) ? 1 : 0;
                    m_step = 6;
                end
            end else if (m_open != 0) begin
                m_win++;
                if (m_win == LW) begin m_open = 0; m_busy = 1; m_prog = 0; end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(int'(dec_valid) == m_dv, "R10 dec_valid vs model", int'(dec_valid), m_dv);
            chk(int'(dec_commit) == m_dc, "R4 dec_commit vs model", int'(dec_commit), m_dc);
            chk(int'(prot_on) == m_prot, "R11 prot_on vs model", int'(prot_on), m_prot);
            chk(int'(prog_busy) == m_busy, "R2 prog_busy vs model", int'(prog_busy), m_busy);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_chk++; n_fail++;
            $display("FAIL R2 watchdog expired actual=%0d expected=0", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // One write, called at a falling edge; checks the decision that follows.
    task automatic wr(input logic [14:0] a, input logic [7:0] d, input bit exp_c, input string req);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
        chk(dec_valid === 1'b1, req, int'(dec_valid), 1);
        chk(dec_commit === exp_c, req, int'(dec_commit), int'(exp_c));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        idle(LW + PC + 2);
    endtask

    task automatic lock_seq(input int gap);
        wr(15'h5555, 8'hAA, 1'b0, "R5 lock step 1 discarded"); idle(gap);
        wr(15'h2AAA, 8'h55, 1'b0, "R5 lock step 2 discarded"); idle(gap);
        wr(15'h5555, 8'hA0, 1'b0, "R5 lock step 3 discarded");
    endtask

    task automatic unlock_seq();
        wr(15'h5555, 8'hAA, 1'b0, "R8 unlock step 1");
        wr(15'h2AAA, 8'h55, 1'b0, "R8 unlock step 2");
        wr(15'h5555, 8'h80, 1'b0, "R8 unlock step 3");
        wr(15'h5555, 8'hAA, 1'b0, "R8 unlock step 4");
        wr(15'h2AAA, 8'h55, 1'b0, "R8 unlock step 5");
        wr(15'h5555, 8'h20, 1'b0, "R8 unlock step 6");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        chk(prot_on === 1'b0, "R1 reset prot_on", int'(prot_on), 0);
        chk(prog_busy === 1'b0, "R1 reset prog_busy", int'(prog_busy), 0);
        chk(dec_valid === 1'b0, "R1 reset dec_valid", int'(dec_valid), 0);

        // Unprotected ordinary page.
        wr(15'h0123, 8'h11, 1'b1, "R4 unprotected write commits");
        wr(15'h0124, 8'h22, 1'b1, "R4 second byte commits");
        idle(1);
        chk(dec_valid === 1'b0, "R10 single-cycle decision", int'(dec_valid), 0);
        settle();

        // Lock then data; protection changes only at the end of the period.
        lock_seq(0);
        wr(15'h0200, 8'h33, 1'b1, "R6 data after lock commits");
        idle(LW);
        chk(prog_busy === 1'b1, "R2 busy after window", int'(prog_busy), 1);
        idle(PC - 1);
        chk(prot_on === 1'b0, "R11 prot unchanged before end", int'(prot_on), 0);
        chk(prog_busy === 1'b1, "R2 busy lasts PROG_CYCLES", int'(prog_busy), 1);
        idle(1);
        chk(prog_busy === 1'b0, "R2 busy released", int'(prog_busy), 0);
        chk(prot_on === 1'b1, "R5 protection on at period end", int'(prot_on), 1);

        // Protected write with no sequence; write during busy.
        wr(15'h0300, 8'h44, 1'b0, "R7 protected write discarded");
        idle(LW);
        chk(prog_busy === 1'b1, "R7 discarded write still programs", int'(prog_busy), 1);
        wr_valid = 1'b1; wr_addr = 15'h5555; wr_data = 8'hAA;
        @(negedge clk); wr_valid = 1'b0;
        chk(dec_valid === 1'b0, "R3 busy write ignored", int'(dec_valid), 0);
        settle();

        // Protected mismatch: the rest of the phase is ordinary (discarded).
        wr(15'h5555, 8'hAA, 1'b0, "R9 step 1 matched");
        wr(15'h2AAA, 8'h56, 1'b0, "R9 mismatch under protection discarded");
        wr(15'h5555, 8'hA0, 1'b0, "R9 no resume after mismatch");
        settle();

        // Lock sequence with the longest allowed gaps, then data.
        lock_seq(LW - 1);
        idle(LW - 1);
        wr(15'h0400, 8'h55, 1'b1, "R2 gap of LOAD_WIN keeps phase; R6 commit");
        settle();
        chk(prot_on === 1'b1, "R5 still protected", int'(prot_on), 1);

        // Unlock without data.
        unlock_seq();
        idle(LW + PC - 1);
        chk(prot_on === 1'b1, "R11 unlock waits for period end", int'(prot_on), 1);
        idle(1);
        chk(prot_on === 1'b0, "R8 protection removed", int'(prot_on), 0);

        // Unprotected mismatch, and sequence not at phase start.
        wr(15'h5555, 8'hAA, 1'b0, "R9 step 1 consumed");
        wr(15'h1234, 8'h12, 1'b1, "R9 mismatch unprotected commits");
        settle();
        wr(15'h0001, 8'h01, 1'b1, "R4 ordinary first write");
        wr(15'h5555, 8'hAA, 1'b1, "R9 key byte mid-phase is ordinary");
        settle();

        // Lock without data; then a sequence broken by the window.
        lock_seq(0);
        settle();
        chk(prot_on === 1'b1, "R5 lock with no data still protects", int'(prot_on), 1);
        wr(15'h5555, 8'hAA, 1'b0, "R7 step 1 consumed");
        idle(LW);
        wr_valid = 1'b1; wr_addr = 15'h2AAA; wr_data = 8'h55;
        @(negedge clk); wr_valid = 1'b0;
        chk(dec_valid === 1'b0, "R3 step during busy ignored", int'(dec_valid), 0);
        settle();
        wr(15'h0500, 8'h66, 1'b0, "R7 new phase still protected");
        settle();

        // Unlock with data bytes.
        unlock_seq();
        wr(15'h0600, 8'h77, 1'b1, "R6 data after unlock commits");
        settle();
        chk(prot_on === 1'b0, "R8 unlock with data clears", int'(prot_on), 0);

        cmp_on = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule